// File: doc/BRIEF.md
# Mode-Selectable Clock Enable Divider

This block runs on one fast reference clock. It produces four clock-enable strobes for the downstream domains: synchronous logic, FIFO read (one parallel load per 60-bit serial word), multi-serial and serial-time. Each strobe is high for exactly one reference cycle and repeats at the divided rate. A 3-bit operating-mode code selects the whole set of coupled division ratios at once. The block has no clock gating and no clock multiplexing. The logic downstream uses the strobes as clock enables on the reference clock.

A synchronous reset does three things. It loads the mode code into a holding register, clears every divider counter, and parks a two-state sequencer in its hold state. While the reset input stays low, the mode input is ignored. When reset is released, all strobes fire together in the first running cycle, so the phases of every domain stay aligned. After that, each strobe repeats at its own period.

The sequencer has two states:
- `SEQ_HOLD`: enables are low and counters are held at zero.
- `SEQ_RUN`: counters advance.

It has two transitions:
- `SEQ_HOLD` to `SEQ_RUN` on the first clock edge that samples reset low.
- Any state to `SEQ_HOLD` on a clock edge that samples reset high.

The serial-time strobe is always a copy of the synchronous-logic strobe.

Top module: `clkdiv_modes`

## Requirements
- R1: After any clock edge that samples `srst` high, all four enables are low during the following cycle.
- R2: In the first cycle after the first edge that samples `srst` low, all four enables are high together.
- R3: With mode code 0 or 1 latched (PLL modes), `en_sync` repeats every 10 cycles, `en_fifo_rd` every 60 and `en_mserial` every 5. Each is high in running cycle k exactly when k is a multiple of its period, counting k from 0 at the first running cycle.
- R4: With mode code 2 latched (external 320 MHz), `en_sync` has period 1 (always high), `en_fifo_rd` period 12 and `en_mserial` period 1.
- R5: With mode code 3 latched (external 480 MHz), `en_sync` has period 2, `en_fifo_rd` period 12 and `en_mserial` period 1.
- R6: With mode code 4 latched (PLL override), the periods are 10, 60 and 5 for `en_sync`, `en_fifo_rd` and `en_mserial`.
- R7: Mode codes 5, 6 and 7 produce the same periods as code 0.
- R8: `en_stime` equals `en_sync` in every cycle.
- R9: The mode code is captured only on edges where `srst` is high. Changes to `mode_sel` while `srst` is low do not alter any enable until the next reset.
- R10: Any enable whose period exceeds 1 is high for a single cycle per period. Whenever `en_fifo_rd` is high, `en_sync` and `en_mserial` are also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| srst | input | 1 | Synchronous reset, active high; also the window in which the mode is captured |
| mode_sel | input | 3 | Operating-mode code: 0/1 PLL, 2 external 320 MHz, 3 external 480 MHz, 4 PLL override, 5-7 treated as 0 |
| en_sync | output | 1 | Synchronous-logic clock enable |
| en_fifo_rd | output | 1 | FIFO-read / parallel-load clock enable |
| en_mserial | output | 1 | Multi-serial clock enable |
| en_stime | output | 1 | Serial-time clock enable, identical to `en_sync` |

## Verification
A counter that slips or wraps at the wrong count shows up as an enable in the wrong running cycle. This is visible within one period of that domain: at most 60 cycles after release for the FIFO-read strobe, and 5 or 10 cycles for the others. A wrongly decoded or wrongly latched mode changes the spacing of at least one strobe within the first 12 running cycles. A sequencer stuck in the wrong state shows at the ports in the very first cycle after reset, either as enables high during reset or as a missing common first pulse. Mode scrambling while running exposes a holding register that samples outside reset, at the next strobe of any affected domain.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Mode codes seen on the mode_sel input
    typedef enum logic [2:0] {
        MODE_PLL_LO = 3'd0,
        MODE_PLL_HI = 3'd1,
        MODE_EXT_LO = 3'd2,
        MODE_EXT_HI = 3'd3,
        MODE_BYPASS = 3'd4
    } mode_e;

    // Sequencer states
    typedef enum logic {
        SEQ_HOLD = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Domain indices into the divider array
    localparam int DOM_SYNC  = 0;
    localparam int DOM_FIFO  = 1;
    localparam int DOM_MSER  = 2;
    localparam int NUM_DOMS  = 3;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/clkdiv_ratio_latch.sv
module clkdiv_ratio_latch
    import clkdiv_pkg::*;
#(
    parameter int DIV_W        = 7,
    parameter int SYNC_DIV_PLL = 10,
    parameter int FIFO_DIV_PLL = 60,
    parameter int MSER_DIV_PLL = 5,
    parameter int SYNC_DIV_E32 = 1,
    parameter int SYNC_DIV_E48 = 2,
    parameter int FIFO_DIV_EXT = 12,
    parameter int MSER_DIV_EXT = 1
) (
    input  logic             clk,
    input  logic             srst,
    input  logic [2:0]       mode_sel,
    output logic [DIV_W-1:0] div_sync,
    output logic [DIV_W-1:0] div_fifo,
    output logic [DIV_W-1:0] div_mser
);

    mode_e mode_q;

    // Mode is captured only while reset is asserted
    always_ff @(posedge clk) begin
        if (srst) begin
            mode_q <= mode_e'(mode_sel);
        end
    end

    always_comb begin
        unique case (mode_q)
            MODE_EXT_LO: begin
                div_sync = DIV_W'(SYNC_DIV_E32);
                div_fifo = DIV_W'(FIFO_DIV_EXT);
                div_mser = DIV_W'(MSER_DIV_EXT);
            end
            MODE_EXT_HI: begin
                div_sync = DIV_W'(SYNC_DIV_E48);
                div_fifo = DIV_W'(FIFO_DIV_EXT);
                div_mser = DIV_W'(MSER_DIV_EXT);
            end
            default: begin
                // PLL low/high, PLL override and all unused codes
                div_sync = DIV_W'(SYNC_DIV_PLL);
                div_fifo = DIV_W'(FIFO_DIV_PLL);
                div_mser = DIV_W'(MSER_DIV_PLL);
            end
        endcase
    end

endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
    import clkdiv_pkg::*;
(
    input  logic clk,
    input  logic srst,
    output logic run
);

    seq_state_e state_q;
    seq_state_e state_d;

    always_ff @(posedge clk) begin
        if (srst) begin
            state_q <= SEQ_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_HOLD: state_d = SEQ_RUN;
            SEQ_RUN:  state_d = SEQ_RUN;
            default:  state_d = SEQ_HOLD;
        endcase
    end

    always_comb begin
        run = (state_q == SEQ_RUN);
    end

endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             en
);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q >= div - DIV_W'(1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    always_comb begin
        en = run && (cnt_q == '0);
    end

    // R10: single-cycle strobe whenever the period exceeds one
    assert_single_pulse_R10: assert property (
        @(posedge clk) disable iff (!run)
        (en && (div > DIV_W'(1))) |=> !en
    );

    // R10: phase counter never reaches the divisor while running
    assert_cnt_in_range_R10: assert property (
        @(posedge clk) disable iff (!run)
        cnt_q < div
    );

endmodule

// File: rtl/clkdiv_modes.sv
module clkdiv_modes
    import clkdiv_pkg::*;
#(
    parameter int SYNC_DIV_PLL = 10,
    parameter int FIFO_DIV_PLL = 60,
    parameter int MSER_DIV_PLL = 5,
    parameter int SYNC_DIV_E32 = 1,
    parameter int SYNC_DIV_E48 = 2,
    parameter int FIFO_DIV_EXT = 12,
    parameter int MSER_DIV_EXT = 1
) (
    input  logic       clk,
    input  logic       srst,
    input  logic [2:0] mode_sel,
    output logic       en_sync,
    output logic       en_fifo_rd,
    output logic       en_mserial,
    output logic       en_stime
);

    localparam int MAX_DIV = max_of(max_of(max_of(SYNC_DIV_PLL, FIFO_DIV_PLL),
                                           max_of(MSER_DIV_PLL, SYNC_DIV_E32)),
                                    max_of(max_of(SYNC_DIV_E48, FIFO_DIV_EXT),
                                           MSER_DIV_EXT));
    localparam int DIV_W   = $clog2(MAX_DIV + 1);

    logic [DIV_W-1:0] div_arr [NUM_DOMS];
    logic [NUM_DOMS-1:0] en_vec;
    logic run;

    clkdiv_ratio_latch #(
        .DIV_W        (DIV_W),
        .SYNC_DIV_PLL (SYNC_DIV_PLL),
        .FIFO_DIV_PLL (FIFO_DIV_PLL),
        .MSER_DIV_PLL (MSER_DIV_PLL),
        .SYNC_DIV_E32 (SYNC_DIV_E32),
        .SYNC_DIV_E48 (SYNC_DIV_E48),
        .FIFO_DIV_EXT (FIFO_DIV_EXT),
        .MSER_DIV_EXT (MSER_DIV_EXT)
    ) u_ratio (
        .clk      (clk),
        .srst     (srst),
        .mode_sel (mode_sel),
        .div_sync (div_arr[DOM_SYNC]),
        .div_fifo (div_arr[DOM_FIFO]),
        .div_mser (div_arr[DOM_MSER])
    );

    clkdiv_seq u_seq (
        .clk  (clk),
        .srst (srst),
        .run  (run)
    );

    for (genvar g = 0; g < NUM_DOMS; g++) begin : g_dom
        clkdiv_counter #(
            .DIV_W (DIV_W)
        ) u_cnt (
            .clk (clk),
            .run (run),
            .div (div_arr[g]),
            .en  (en_vec[g])
        );
    end

    always_comb begin
        en_sync    = en_vec[DOM_SYNC];
        en_fifo_rd = en_vec[DOM_FIFO];
        en_mserial = en_vec[DOM_MSER];
        en_stime   = en_vec[DOM_SYNC];
    end

    // R2: every domain fires together right after reset release
    assert_common_first_R2: assert property (
        @(posedge clk) disable iff (srst)
        $fell(srst) |=> (en_sync && en_fifo_rd && en_mserial && en_stime)
    );

    // R10: the slowest strobe only lands on edges of the faster domains
    assert_fifo_aligned_R10: assert property (
        @(posedge clk) disable iff (srst)
        en_fifo_rd |-> (en_sync && en_mserial)
    );

endmodule

// File: tb/clkdiv_modes_bench.sv
`timescale 1ns/1ps
module clkdiv_modes_bench;

    logic       clk = 1'b0;
    logic       srst = 1'b1;
    logic [2:0] mode_sel = 3'd0;
    logic       en_sync, en_fifo_rd, en_mserial, en_stime;

    int vectors = 0;
    int errors  = 0;

    always #2 clk = ~clk;

    clkdiv_modes u_clkdiv_modes (
        .clk        (clk),
        .srst       (srst),
        .mode_sel   (mode_sel),
        .en_sync    (en_sync),
        .en_fifo_rd (en_fifo_rd),
        .en_mserial (en_mserial),
        .en_stime   (en_stime)
    );

    // Expected period per domain (0 sync, 1 fifo, 2 multi-serial)
    function automatic int exp_div(input logic [2:0] code, input int dom);
        case (code)
            3'd2:    return (dom == 0) ? 1 : ((dom == 1) ? 12 : 1);
            3'd3:    return (dom == 0) ? 2 : ((dom == 1) ? 12 : 1);
            default: return (dom == 0) ? 10 : ((dom == 1) ? 60 : 5);
        endcase
    endfunction

    function automatic string mode_tag(input logic [2:0] code);
        case (code)
            3'd0, 3'd1: return "R3";
            3'd2:       return "R4";
            3'd3:       return "R5";
            3'd4:       return "R6";
            default:    return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input string name, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, name, act, exp, $time);
        end
    endtask

    task automatic trial(input logic [2:0] code, input int hold, input int run_len, input bit scramble);
        string tag;
        @(negedge clk);
        srst     = 1'b1;
        mode_sel = code;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check("R1", "en_sync",    en_sync,    1'b0);
            check("R1", "en_fifo_rd", en_fifo_rd, 1'b0);
            check("R1", "en_mserial", en_mserial, 1'b0);
            check("R1", "en_stime",   en_stime,   1'b0);
        end
        srst = 1'b0;
        for (int i = 0; i < run_len; i++) begin
            logic es, ef, em;
            @(negedge clk);
            es = ((i % exp_div(code, 0)) == 0);
            ef = ((i % exp_div(code, 1)) == 0);
            em = ((i % exp_div(code, 2)) == 0);
            if (i == 0)        tag = "R2";
            else if (scramble) tag = "R9";
            else               tag = mode_tag(code);
            check(tag,  "en_sync",    en_sync,    es);
            check(tag,  "en_fifo_rd", en_fifo_rd, ef);
            check(tag,  "en_mserial", en_mserial, em);
            check("R8", "en_stime",   en_stime,   en_sync);
            if (en_fifo_rd) check("R10", "fifo_vs_sync_mser", en_sync && en_mserial, 1'b1);
            if (scramble) mode_sel = 3'($urandom);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0C1D));
        // directed: every mode code, runs longer than two slowest periods
        for (int c = 0; c < 8; c++) begin
            trial(3'(c), 2, 130, 1'b0);
        end
        // minimum reset pulse and mode changes while running
        trial(3'd3, 1, 40, 1'b0);
        trial(3'd2, 3, 100, 1'b1);
        trial(3'd0, 1, 130, 1'b1);
        trial(3'd4, 2, 70, 1'b1);
        // constrained random trials
        for (int t = 0; t < 24; t++) begin
            trial(3'($urandom % 8), 1 + int'($urandom % 4), 20 + int'($urandom % 150),
                  1'($urandom % 2));
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule